// File: doc/BRIEF.md
# Multi-digit decimal adder

This block adds two unsigned decimal numbers held in packed BCD form, four bits per digit with the least significant digit in bits 3:0, together with a single carry input. It produces a packed BCD sum of the same number of digits and a decimal carry out. The number of digits is the parameter `DIGITS`, with a default of 4.

Each digit slice first adds its two operand digits and the carry from the slice below as a plain 4-bit binary sum with a fifth carry bit. A detector then decides whether that binary result is beyond the decimal range. When the detector fires, the slice adds six to the low four bits and sends a carry of one to the next slice up. Otherwise the slice passes the binary digit through unchanged and sends no carry. The slices form a ripple chain that starts at the lowest digit. The carry from the top slice becomes the block's carry out. Sum and carry out are captured in one output register, so a result appears one clock after its operands are presented. Operands are assumed to hold only digit codes 0 to 9.

Top module: `bcd_ripple_adder`

## Requirements
- R1: While `rst_n` is low, `sum` and `cout` are held at zero.
- R2: A result appears on `sum` and `cout` at the first rising clock edge after the operands and `cin` are applied, and it holds until the next edge.
- R3: When both operands hold only valid digits (0 to 9), every 4-bit digit of `sum` is in the range 0 to 9.
- R4: A digit slice whose binary sum of both operand digits and incoming carry is 9 or less outputs that sum unchanged and carries nothing. A slice whose sum is 10 or more outputs that sum plus 6, keeps the low four bits, and carries one. For example, 8 + 5 gives digit 3 with carry 1.
- R5: A decimal carry ripples through every digit. With all-nines plus zero plus `cin` = 1, the result is all zeros with `cout` = 1.
- R6: `cin` = 1 adds one unit to the least significant digit.
- R7: For valid operands, the decimal value of `sum` plus `cout` times 10^DIGITS equals A + B + `cin`.
- R8: The largest case, all nines plus all nines plus carry in, gives all nines in `sum` with `cout` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the result register updates on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; clears the result |
| a | input | 4*DIGITS | First operand, packed BCD, lowest digit in bits 3:0 |
| b | input | 4*DIGITS | Second operand, packed BCD |
| cin | input | 1 | Carry into the lowest digit |
| sum | output | 4*DIGITS | Registered packed BCD sum |
| cout | output | 1 | Registered decimal carry out of the top digit |

## Verification
The hardest case to reach from the ports is a carry that starts in the lowest slice and has to pass through every higher slice. Each of those slices must sit at exactly nine, so that only the incoming carry pushes it over the limit. Random digits seldom line up that way, so the stimulus includes all-nines operands paired with zero plus `cin`, and with a one in the lowest digit. It also includes mixed patterns in which each digit pair sums to exactly 9 or exactly 10. Random valid digits then cover the rest, and the bench compares every result against an integer reference.

// File: rtl/bcd_ripple_adder.sv
module bcd_ripple_adder #(
  parameter int DIGITS = 4,
  localparam int W = 4 * DIGITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  localparam logic [W-1:0] ALL_NINES = {DIGITS{4'h9}};

  logic [DIGITS:0] dcarry;
  logic [W-1:0]    dsum;

  assign dcarry[0] = cin;

  for (genvar g = 0; g < DIGITS; g++) begin : g_slice
    logic [4:0] raw;
    logic       fix;

    assign raw = {1'b0, a[4*g +: 4]} + {1'b0, b[4*g +: 4]} + {4'b0, dcarry[g]};
    assign fix = raw[4] | (raw[3] & raw[2]) | (raw[3] & raw[1]);
    assign dsum[4*g +: 4] = raw[3:0] + (fix ? 4'd6 : 4'd0);
    assign dcarry[g+1] = fix;

    // R4: correction fires exactly when the binary digit sum reaches ten
    assert_carry_rule_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fix == (raw >= 5'd10));

    // R3: registered digits stay decimal
    assert_digit_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sum[4*g +: 4] <= 4'd9);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum  <= '0;
      cout <= 1'b0;
    end else begin
      sum  <= dsum;
      cout <= dcarry[DIGITS];
    end
  end

  // R5: full-length ripple from the lowest digit
  assert_full_ripple_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(a) == ALL_NINES && $past(b) == '0 && $past(cin))
    |-> (sum == '0 && cout));

  // R7: zero in gives zero out
  assert_zero_sum_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(a) == '0 && $past(b) == '0 && !$past(cin))
    |-> (sum == '0 && !cout));

endmodule

// File: tb/sim_bcd_ripple_adder.sv
module sim_bcd_ripple_adder;
  localparam int D = 4;
  localparam int W = 4 * D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic cin = 1'b0;
  logic [W-1:0] sum;
  logic cout;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic [W-1:0] prev_sum = '0;
  logic         prev_cout = 1'b0;

  bcd_ripple_adder #(.DIGITS(D)) u0 (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
  );

  always #2.5 clk = ~clk;

  function automatic longint to_int(input logic [W-1:0] v);
    longint r = 0;
    for (int i = D - 1; i >= 0; i--) r = r * 10 + longint'(v[4*i +: 4]);
    return r;
  endfunction

  function automatic logic [W-1:0] to_bcd(input longint v);
    logic [W-1:0] r = '0;
    longint t = v;
    for (int i = 0; i < D; i++) begin
      r[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  function automatic longint pow10d();
    longint p = 1;
    for (int i = 0; i < D; i++) p = p * 10;
    return p;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] es, input logic ec);
    compared++;
    if (sum !== es || cout !== ec) begin
      mismatched++;
      $display("FAIL %s: sum=%h cout=%b expected sum=%h cout=%b", tag, sum, cout, es, ec);
    end
  endtask

  // Apply operands after a falling edge, confirm the old result still holds (R2),
  // then sample the new result 1 ns after the rising edge.
  task automatic step(input string tag, input logic [W-1:0] xa, input logic [W-1:0] xb,
                      input logic xc);
    longint total;
    logic [W-1:0] es;
    logic ec;
    @(negedge clk);
    a = xa; b = xb; cin = xc;
    #1;
    check("R2 hold", prev_sum, prev_cout);
    total = to_int(xa) + to_int(xb) + longint'(xc);
    es = to_bcd(total % pow10d());
    ec = (total >= pow10d());
    @(posedge clk);
    #1;
    check(tag, es, ec);
    prev_sum = es;
    prev_cout = ec;
  endtask

  function automatic logic [W-1:0] rand_bcd();
    logic [W-1:0] r;
    for (int i = 0; i < D; i++) r[4*i +: 4] = 4'($urandom_range(9, 0));
    return r;
  endfunction

  initial begin
    #200000;
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] nines;
    nines = {D{4'h9}};
    a = nines; b = nines; cin = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", '0, 1'b0);
    @(negedge clk);
    a = '0; b = '0; cin = 1'b0;
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R1 after release", '0, 1'b0);

    step("R4 8+5", 16'h0008, 16'h0005, 1'b0);
    step("R4 4+5 no fix", 16'h0004, 16'h0005, 1'b0);
    step("R4 9+1 boundary", 16'h0009, 16'h0001, 1'b0);
    step("R4 9+9", 16'h0009, 16'h0009, 1'b0);
    step("R6 cin", 16'h0000, 16'h0000, 1'b1);
    step("R6 cin carries", 16'h0004, 16'h0005, 1'b1);
    step("R5 ripple cin", nines, 16'h0000, 1'b1);
    step("R5 ripple digit", nines, 16'h0001, 1'b0);
    step("R7 mixed 9/10", 16'h4536, 16'h5474, 1'b0);
    step("R7 zero", 16'h0000, 16'h0000, 1'b0);
    step("R8 max", nines, nines, 1'b1);
    step("R3 carry into top", 16'h5000, 16'h5000, 1'b0);
    for (int n = 0; n < 400; n++)
      step("R7 random", rand_bcd(), rand_bcd(), 1'($urandom_range(1, 0)));

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule